// File: doc/BRIEF.md
# Zero-Cross Gain Update Sequencer

This block sits between a volume-control register port and the gain latches of a multi-channel attenuator. Each channel holds a written 8-bit gain code and an active code that drives the resistor ladder. A normal write does not reach the ladder right away. The channel marks itself busy and waits for a safe moment: the next rising zero crossing of that channel's input sign, or the end of a restartable timeout when the input is silent. When either happens, the active code is updated and busy drops. This avoids audible clicks when the gain changes.

Instant writes skip the wait. A mute pin mutes every channel and later restores the written codes, and both of these transitions use the same crossing-or-timeout gating. A test-mode input holds every output at the mute code and blocks ordinary writes. While in test mode, a force command can still load one code into all channels at once. Code 00h means mute. Any nonzero code c gives a gain of (c − 224) × 0.5 dB, so FFh is +15.5 dB.

Top module: `zc_gain_seq`

## Requirements
- R1: After reset every gain output reads 00h (mute) and every busy flag is low, whatever the mute pin level.
- R2: A normal write (wr_en_i bit c high for one cycle, code on code_i) sets busy_o[c] on the next cycle and leaves gain c unchanged. A rising crossing, meaning sign_i[c] going from 1 (negative) to 0, applies the code exactly 3 cycles after sign_i changes and clears busy.
- R3: A falling crossing (sign_i[c] from 0 to 1) neither applies a pending code nor clears busy.
- R4: With no rising crossing, a pending code is applied exactly TIMEOUT_CYC cycles after the write edge. It is still unapplied one cycle earlier.
- R5: A normal write to a busy channel replaces the pending code and restarts the timeout. The earlier code never reaches the output.
- R6: An instant write (inst_en_i bit c) puts the code on gain c at the write edge and leaves busy_o[c] low.
- R7: Setting several wr_en_i bits in the same cycle loads one code into those channels. Each channel then waits for its own crossing, independently of the others.
- R8: When mute_n_i goes low, every channel goes busy 3 cycles later and drops to 00h through the gated path. When mute_n_i returns high, the last written codes come back the same way, including codes written while muted.
- R9: While test_mode_i is high, all gain outputs read 00h and normal and instant writes are ignored. force_i loads code_i into every channel's active code at once, and that code shows when test mode ends.
- R10: A rising crossing that lands in the same cycle as the timeout latches the code once and clears busy and the timer. The next write then waits the full TIMEOUT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | NCH | Normal (gated) write strobe per channel |
| inst_en_i | input | NCH | Instant write strobe per channel |
| force_i | input | 1 | Force-latch strobe, all channels |
| test_mode_i | input | 1 | Test mode: outputs muted, writes blocked |
| code_i | input | 8 | Gain code for the strobed write |
| sign_i | input | NCH | Input polarity per channel, 1 = negative (asynchronous) |
| mute_n_i | input | 1 | Mute pin, low = mute (asynchronous) |
| gain_o | output | 8*NCH | Active gain codes, channel c at bits [8c+7:8c] |
| busy_o | output | NCH | Update pending per channel |

## Verification
A write lands at the clock edge that samples the strobe. Busy and instant codes are visible from that edge. A timeout update shows TIMEOUT_CYC edges later. A rising sign change takes effect on the third edge after it is driven, because of two synchronizer stages and an edge register. A mute pin change raises busy on its third edge and settles TIMEOUT_CYC edges after that. The bench drives inputs and reads outputs at falling edges, and it counts edges from each stimulus. For every gated update it checks the output one edge before the due cycle (old value) and again at the due cycle (new value).

// File: rtl/zgs_pkg.sv
package zgs_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MUTE_CODE = '0;
endpackage

// File: rtl/zgs_sync.sv
module zgs_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/zgs_edge_det.sv
module zgs_edge_det #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sign_i,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] sign_s, sign_prev_q;

  zgs_sync #(.W(NCH), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sign_i), .q_o(sign_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sign_prev_q <= '0;
    else        sign_prev_q <= sign_s;
  end

  // negative in the previous sample, non-negative now
  assign rise_o = sign_prev_q & ~sign_s;
endmodule

// File: rtl/zgs_chan.sv
module zgs_chan
  import zgs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 22000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  logic  inst_i,
  input  logic  frc_i,
  input  logic  test_i,
  input  logic  muted_i,
  input  logic  mute_evt_i,
  input  code_t code_i,
  input  logic  zc_i,
  output code_t act_o,
  output logic  busy_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  code_t            wcode_q, wcode_d;
  code_t            act_q, act_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic  imm_ld, gate_evt, tmo, fire;
  code_t desired;

  assign imm_ld   = frc_i | (~test_i & inst_i);
  assign gate_evt = (~test_i & wr_i) | mute_evt_i;
  assign tmo      = (cnt_q == CNT_LAST);
  assign fire     = busy_q & (zc_i | tmo);
  assign desired  = muted_i ? MUTE_CODE : wcode_q;

  always_comb begin
    wcode_d = wcode_q;
    act_d   = act_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (frc_i || (!test_i && (wr_i || inst_i)))
      wcode_d = code_i;
    if (imm_ld) begin
      act_d  = (frc_i || !muted_i) ? code_i : MUTE_CODE;
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (gate_evt) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (fire) begin
      act_d  = desired;
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcode_q <= MUTE_CODE;
      act_q   <= MUTE_CODE;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      wcode_q <= wcode_d;
      act_q   <= act_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
    end
  end

  assign act_o  = act_q;
  assign busy_o = busy_q;

  // R6
  inst_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_i && !test_i && !frc_i) |=> !busy_q);

  // R2
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !zc_i && !tmo && !imm_ld) |=> $stable(act_q));

  // R4
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(TIMEOUT_CYC)));

  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0));
endmodule

// File: rtl/zc_gain_seq.sv
module zc_gain_seq
  import zgs_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TIMEOUT_CYC = 22000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        wr_en_i,
  input  logic [NCH-1:0]        inst_en_i,
  input  logic                  force_i,
  input  logic                  test_mode_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic [NCH-1:0]        sign_i,
  input  logic                  mute_n_i,
  output logic [NCH*CODE_W-1:0] gain_o,
  output logic [NCH-1:0]        busy_o
);
  logic           mute_n_s, mute_n_prev_q, mute_evt, muted;
  logic [NCH-1:0] zc;

  zgs_sync #(.W(1), .RST_VAL(1'b1)) u_mute_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mute_n_i), .q_o(mute_n_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_n_prev_q <= 1'b1;
    else        mute_n_prev_q <= mute_n_s;
  end

  assign mute_evt = mute_n_s ^ mute_n_prev_q;
  assign muted    = ~mute_n_s;

  zgs_edge_det #(.NCH(NCH)) u_zc (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .rise_o(zc)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    code_t act;

    zgs_chan #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_en_i[c]),
      .inst_i     (inst_en_i[c]),
      .frc_i      (force_i),
      .test_i     (test_mode_i),
      .muted_i    (muted),
      .mute_evt_i (mute_evt),
      .code_i     (code_i),
      .zc_i       (zc[c]),
      .act_o      (act),
      .busy_o     (busy_o[c])
    );

    assign gain_o[c*CODE_W +: CODE_W] = test_mode_i ? MUTE_CODE : act;
  end
endmodule

// File: tb/zc_gain_seq_tb.sv
module zc_gain_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 16;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] wr_en = '0, inst_en = '0, sign = '0;
  logic           force_l = 1'b0, test_mode = 1'b0, mute_n = 1'b1;
  logic [7:0]     code = '0;
  logic [15:0]    gain;
  logic [NCH-1:0] busy;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_g [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_gain_seq #(.NCH(NCH), .TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .inst_en_i(inst_en),
    .force_i(force_l), .test_mode_i(test_mode), .code_i(code),
    .sign_i(sign), .mute_n_i(mute_n), .gain_o(gain), .busy_o(busy)
  );

  // {channel mask, instant, code}
  localparam logic [10:0] VEC [6] = '{
    {2'b01, 1'b0, 8'hE0}, {2'b10, 1'b0, 8'hC8}, {2'b11, 1'b1, 8'hFF},
    {2'b01, 1'b1, 8'h01}, {2'b11, 1'b0, 8'hA0}, {2'b10, 1'b1, 8'h80}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic chk_g(input string tag);
    chk(tag, gain, {exp_g[1], exp_g[0]});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m, input logic inst, input logic [7:0] c);
    wr_en = inst ? 2'b00 : m;
    inst_en = inst ? m : 2'b00;
    code = c;
    step(1);
    wr_en = '0; inst_en = '0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", wd);
        finish_run();
      end
    end
  end

  initial begin
    exp_g[0] = 8'h00; exp_g[1] = 8'h00;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk_g("R1 gain after reset");
    chk("R1 busy after reset", {14'd0, busy}, 16'd0);

    foreach (VEC[i]) begin
      logic [1:0] m;
      logic [7:0] c;
      m = VEC[i][10:9];
      c = VEC[i][7:0];
      wr(m, VEC[i][8], c);
      if (VEC[i][8]) begin
        for (int k = 0; k < NCH; k++) if (m[k]) exp_g[k] = c;
        chk_g("R6 instant gain");
        chk("R6 instant busy", {14'd0, busy}, 16'd0);
      end else begin
        chk("R2 busy set", {14'd0, busy}, {14'd0, m});
        chk_g("R2 gain held");
        sign = 2'b11;
        step(4);
        chk("R3 falling edge keeps busy", {14'd0, busy}, {14'd0, m});
        chk_g("R3 falling edge no apply");
        sign = 2'b00;
        step(2);
        chk_g("R2 not before third edge");
        step(1);
        for (int k = 0; k < NCH; k++) if (m[k]) exp_g[k] = c;
        chk_g("R2 applied on rising crossing");
        chk("R2 busy cleared", {14'd0, busy}, 16'd0);
      end
      step(2);
    end

    // R4 timeout
    wr(2'b01, 1'b0, 8'h40);
    step(T - 1);
    chk_g("R4 before timeout");
    chk("R4 busy before timeout", {14'd0, busy}, 16'd1);
    step(1);
    exp_g[0] = 8'h40;
    chk_g("R4 at timeout");
    chk("R4 busy cleared", {14'd0, busy}, 16'd0);

    // R5 rewrite restarts timer
    wr(2'b10, 1'b0, 8'h11);
    step(5);
    wr(2'b10, 1'b0, 8'h22);
    step(T - 1);
    chk_g("R5 old code never applied");
    step(1);
    exp_g[1] = 8'h22;
    chk_g("R5 replacement applied at restarted timeout");

    // R7 independent channels
    step(2);
    wr(2'b11, 1'b0, 8'h90);
    sign = 2'b10;
    step(4);
    sign = 2'b00;
    step(3);
    exp_g[1] = 8'h90;
    chk_g("R7 channel 1 first");
    chk("R7 channel 0 still busy", {14'd0, busy}, 16'd1);
    sign = 2'b01;
    step(4);
    sign = 2'b00;
    step(3);
    exp_g[0] = 8'h90;
    chk_g("R7 channel 0 second");
    chk("R7 both idle", {14'd0, busy}, 16'd0);

    // R10 crossing and timeout in the same cycle
    step(2);
    sign = 2'b01;
    step(4);
    wr(2'b01, 1'b0, 8'h5A);
    step(T - 3);
    sign = 2'b00;
    step(2);
    chk_g("R10 held before coincident edge");
    step(1);
    exp_g[0] = 8'h5A;
    chk_g("R10 single latch");
    chk("R10 busy cleared", {14'd0, busy}, 16'd0);
    wr(2'b01, 1'b0, 8'h5B);
    step(T - 1);
    chk_g("R10 timer restarted from zero");
    step(1);
    exp_g[0] = 8'h5B;
    chk_g("R10 next write full timeout");

    // R8 mute pin
    step(2);
    mute_n = 1'b0;
    step(3);
    chk("R8 busy on mute", {14'd0, busy}, 16'd3);
    chk_g("R8 gain held on mute");
    step(T);
    chk("R8 muted gains", gain, 16'h0000);
    wr(2'b01, 1'b0, 8'h70);
    step(T);
    exp_g[0] = 8'h70;
    chk("R8 write while muted stays muted", gain, 16'h0000);
    mute_n = 1'b1;
    step(3 + T);
    chk_g("R8 codes restored");

    // R9 test mode
    step(2);
    test_mode = 1'b1;
    step(1);
    chk("R9 test mode mutes", gain, 16'h0000);
    wr(2'b11, 1'b0, 8'h55);
    wr(2'b11, 1'b1, 8'h66);
    chk("R9 writes ignored busy", {14'd0, busy}, 16'd0);
    step(T + 2);
    test_mode = 1'b0;
    step(1);
    chk_g("R9 codes unchanged after test");
    test_mode = 1'b1;
    code = 8'h33; force_l = 1'b1;
    step(1);
    force_l = 1'b0;
    test_mode = 1'b0;
    step(1);
    exp_g[0] = 8'h33; exp_g[1] = 8'h33;
    chk_g("R9 force latch both");
    chk("R9 force busy low", {14'd0, busy}, 16'd0);

    finish_run();
  end
endmodule